// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller for Power-Down

This block sits between free-running clock sources and the output pins of a clock generator. It takes an active-low power-down request and stops every output clock without glitches. The request is qualified in the domain of the complement leg of the differential CPU clock. It must be seen low on two back-to-back rising edges of that leg before power-down is accepted. Leaving power-down uses the same rule with the request high.

Each non-CPU output has a stop flag in its own clock domain. The flag changes only on that clock's falling edge, so an output is always parked low, and a restarted output always begins with a full high phase. One of these outputs is the reference clock, and its stop path carries extra pipeline stages. The differential CPU pair is parked with its true leg driven high and its complement leg released, meaning the output enable is off. When a configuration bit is set, both legs are tri-stated instead. A status output reports when everything is parked, and reports again once everything is running.

The block has no data stream, so every pin is plain control or clock. The request may change at any time, and only the two-sample rule decides whether the block acts on it.

Top module: `clkstop_ctrl`

## Requirements
- R1: Power-down is accepted only when `pd_req_n` is 0 at two consecutive rising edges of `cpu_clk_c`, after a one-flop input stage. A low level seen at a single edge has no effect on any output.
- R2: Once power-down is accepted, every bit of `aux_out` stops at a falling edge of its own `src_clk` bit and then stays 0 for as long as power-down lasts.
- R3: In power-down with `cpu_tri_en` = 0, `cpu_t_out` = 1 with `cpu_t_oe` = 1, and `cpu_c_oe` = 0 with `cpu_c_out` = 0.
- R4: In power-down with `cpu_tri_en` = 1, `cpu_t_oe` = 0 and `cpu_c_oe` = 0.
- R5: The reference output, which is bit `REF_IDX` of `aux_out`, passes through `REF_LAG` extra stop stages and still reaches its held-low state.
- R6: No high pulse on any bit of `aux_out` is shorter than the high phase of its source, whether the block is entering or leaving power-down.
- R7: Release requires `pd_req_n` = 1 at two consecutive rising edges of `cpu_clk_c`. A single high sample during power-down is ignored. After release, every output runs again and both CPU enables return to 1.
- R8: While `rst_n` = 0, all stop flags are cleared at once: `aux_out` follows `src_clk`, both CPU enables are 1 and `pd_status` is 0.
- R9: `pd_status` goes to 1 only after every output is parked. It goes back to 0 only after every output is running again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req_n | input | 1 | Active-low power-down request, asynchronous |
| cpu_tri_en | input | 1 | Configuration bit: tri-state both CPU legs in power-down |
| cpu_clk_t | input | 1 | Free-running CPU clock, true leg |
| cpu_clk_c | input | 1 | Free-running CPU clock, complement leg |
| src_clk | input | N_AUX | Free-running non-CPU source clocks |
| aux_out | output | N_AUX | Gated non-CPU clock outputs |
| cpu_t_out | output | 1 | Gated CPU true output |
| cpu_t_oe | output | 1 | Output enable of the CPU true leg |
| cpu_c_out | output | 1 | Gated CPU complement output |
| cpu_c_oe | output | 1 | Output enable of the CPU complement leg |
| pd_status | output | 1 | 1 while all outputs are parked |

## Verification
A request pulse that covers exactly one rising edge of the complement clock shows whether the qualifier really needs two samples, and a one-edge high blip during power-down does the same for release. A held request is applied with the tri-state bit clear and then set, which separates the default park of the CPU pair from the fully released pair. The sources run at three unrelated periods, so a pulse-width monitor can catch truncated or runt pulses on entry and exit. A reset applied in the middle of power-down shows that the flags clear asynchronously.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  // Drive state of the differential CPU pair
  typedef struct packed {
    logic t_out;
    logic t_oe;
    logic c_out;
    logic c_oe;
  } cpu_drive_t;

  // Depth of the stop pipeline for one auxiliary output
  function automatic int stop_depth(input int idx, input int ref_idx,
                                    input int base, input int lag);
    return (idx == ref_idx) ? base + lag : base;
  endfunction

endpackage

// File: rtl/pd_qualifier.sv
// Two-sample qualifier for the power-down request, in the complement CPU domain.
module pd_qualifier (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n,
  output logic pd_act
);
  logic req_q;      // input capture stage
  logic prev_low;   // previous captured sample was low

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q    <= 1'b1;
      prev_low <= 1'b0;
      pd_act   <= 1'b0;
    end else begin
      req_q    <= req_n;
      prev_low <= ~req_q;
      if (prev_low && !req_q)
        pd_act <= 1'b1;
      else if (!prev_low && req_q)
        pd_act <= 1'b0;
    end
  end
endmodule

// File: rtl/aux_gate.sv
// Per-output stop pipeline, updated only on the source's falling edge.
module aux_gate #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_act,
  output logic stop,
  output logic gated
);
  logic [DEPTH-1:0] pipe;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)
      pipe <= '0;
    else
      pipe <= {pipe[DEPTH-2:0], pd_act};
  end

  assign stop  = pipe[DEPTH-1];
  assign gated = clk & ~stop;
endmodule

// File: rtl/cpu_park.sv
// Parks the CPU pair while its true leg is high (complement falling edge).
module cpu_park
  import clkstop_pkg::*;
(
  input  logic       clk_t,
  input  logic       clk_c,
  input  logic       rst_n,
  input  logic       pd_act,
  input  logic       tri_en,
  output logic       stop,
  output cpu_drive_t drv
);
  logic tri_q;

  always_ff @(negedge clk_c or negedge rst_n) begin
    if (!rst_n) begin
      stop  <= 1'b0;
      tri_q <= 1'b0;
    end else begin
      stop  <= pd_act;
      tri_q <= tri_en;
    end
  end

  always_comb begin
    drv.t_out = stop ? 1'b1 : clk_t;
    drv.t_oe  = ~(stop & tri_q);
    drv.c_out = stop ? 1'b0 : clk_c;
    drv.c_oe  = ~stop;
  end
endmodule

// File: rtl/pd_status_agg.sv
// Collects the stop flags of all domains and reports with hysteresis.
module pd_status_agg #(
  parameter int N_FLAGS = 4,
  parameter int SYNC    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_FLAGS-1:0] flags,
  output logic               status
);
  logic [N_FLAGS-1:0] stage [SYNC];

  genvar s;
  generate
    for (s = 0; s < SYNC; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          stage[s] <= '0;
        else if (s == 0)
          stage[s] <= flags;
        else
          stage[s] <= stage[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      status <= 1'b0;
    else if (&stage[SYNC-1])
      status <= 1'b1;
    else if (~|stage[SYNC-1])
      status <= 1'b0;
  end
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int N_AUX       = 3,
  parameter int REF_IDX     = 0,
  parameter int SYNC_STAGES = 2,
  parameter int REF_LAG     = 2
) (
  input  logic             rst_n,
  input  logic             pd_req_n,
  input  logic             cpu_tri_en,
  input  logic             cpu_clk_t,
  input  logic             cpu_clk_c,
  input  logic [N_AUX-1:0] src_clk,
  output logic [N_AUX-1:0] aux_out,
  output logic             cpu_t_out,
  output logic             cpu_t_oe,
  output logic             cpu_c_out,
  output logic             cpu_c_oe,
  output logic             pd_status
);
  localparam int N_FLAGS = N_AUX + 1;

  logic             pd_act;
  logic [N_AUX-1:0] aux_stop;
  logic             cpu_stop;
  cpu_drive_t       cpu_drv;

  pd_qualifier u_qual (
    .clk    (cpu_clk_c),
    .rst_n  (rst_n),
    .req_n  (pd_req_n),
    .pd_act (pd_act)
  );

  genvar i;
  generate
    for (i = 0; i < N_AUX; i++) begin : g_aux
      localparam int DEPTH = stop_depth(i, REF_IDX, SYNC_STAGES, REF_LAG);
      aux_gate #(.DEPTH(DEPTH)) u_gate (
        .clk    (src_clk[i]),
        .rst_n  (rst_n),
        .pd_act (pd_act),
        .stop   (aux_stop[i]),
        .gated  (aux_out[i])
      );
    end
  endgenerate

  cpu_park u_cpu (
    .clk_t  (cpu_clk_t),
    .clk_c  (cpu_clk_c),
    .rst_n  (rst_n),
    .pd_act (pd_act),
    .tri_en (cpu_tri_en),
    .stop   (cpu_stop),
    .drv    (cpu_drv)
  );

  pd_status_agg #(.N_FLAGS(N_FLAGS), .SYNC(SYNC_STAGES)) u_stat (
    .clk    (cpu_clk_c),
    .rst_n  (rst_n),
    .flags  ({cpu_stop, aux_stop}),
    .status (pd_status)
  );

  assign cpu_t_out = cpu_drv.t_out;
  assign cpu_t_oe  = cpu_drv.t_oe;
  assign cpu_c_out = cpu_drv.c_out;
  assign cpu_c_oe  = cpu_drv.c_oe;
endmodule

// File: rtl/clkstop_ctrl_chk.sv
module clkstop_ctrl_chk (
  input logic rst_n,
  input logic cpu_clk_c,
  input logic pd_req_n,
  input logic pd_act,
  input logic cpu_t_out,
  input logic cpu_t_oe,
  input logic cpu_c_oe
);
  // R1: acceptance follows two low input samples
  a_r1_two_low_samples: assert property (@(posedge cpu_clk_c) disable iff (!rst_n)
    $rose(pd_act) |-> (!$past(pd_req_n, 2) && !$past(pd_req_n, 3)));

  // R7: release follows two high input samples
  a_r7_two_high_samples: assert property (@(posedge cpu_clk_c) disable iff (!rst_n)
    $fell(pd_act) |-> ($past(pd_req_n, 2) && $past(pd_req_n, 3)));

  // R3: complement released while true is enabled means true is parked high
  a_r3_true_parked_high: assert property (@(posedge cpu_clk_c) disable iff (!rst_n)
    (!cpu_c_oe && cpu_t_oe) |-> cpu_t_out);

  // R4: the true leg is only ever released together with the complement leg
  a_r4_both_released: assert property (@(posedge cpu_clk_c) disable iff (!rst_n)
    !cpu_t_oe |-> !cpu_c_oe);
endmodule

bind clkstop_ctrl clkstop_ctrl_chk u_chk (
  .rst_n     (rst_n),
  .cpu_clk_c (cpu_clk_c),
  .pd_req_n  (pd_req_n),
  .pd_act    (pd_act),
  .cpu_t_out (cpu_t_out),
  .cpu_t_oe  (cpu_t_oe),
  .cpu_c_oe  (cpu_c_oe)
);

// File: tb/clkstop_ctrl_tb.sv
`timescale 1ns/1ps
module clkstop_ctrl_tb;
  localparam int N = 3;
  localparam int HALF [N] = '{35, 15, 6};

  logic rst_n, pd_req_n, cpu_tri_en, cpu_clk_t, cpu_clk_c;
  logic [N-1:0] src_clk, aux_out;
  logic cpu_t_out, cpu_t_oe, cpu_c_out, cpu_c_oe, pd_status;

  int checks = 0, errors = 0;
  int rises [N];
  int runts = 0;
  bit mon_en = 1'b1;
  bit done = 1'b0;

  clkstop_ctrl u_dut (
    .rst_n(rst_n), .pd_req_n(pd_req_n), .cpu_tri_en(cpu_tri_en),
    .cpu_clk_t(cpu_clk_t), .cpu_clk_c(cpu_clk_c), .src_clk(src_clk),
    .aux_out(aux_out), .cpu_t_out(cpu_t_out), .cpu_t_oe(cpu_t_oe),
    .cpu_c_out(cpu_c_out), .cpu_c_oe(cpu_c_oe), .pd_status(pd_status)
  );

  // 100 MHz CPU pair
  initial begin
    cpu_clk_t = 1'b0;
    forever #5 cpu_clk_t = ~cpu_clk_t;
  end
  assign cpu_clk_c = ~cpu_clk_t;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_src
      initial begin
        src_clk[g] = 1'b0;
        forever #(HALF[g]) src_clk[g] = ~src_clk[g];
      end
    end
  endgenerate

  // Pulse-width monitor for the gated outputs (R6)
  initial begin
    logic [N-1:0] prev;
    time t_up [N];
    bit up_ok [N];
    prev = '0;
    for (int i = 0; i < N; i++) begin
      rises[i] = 0; up_ok[i] = 1'b0; t_up[i] = 0;
    end
    forever begin
      @(aux_out);
      for (int i = 0; i < N; i++) begin
        if (aux_out[i] === 1'b1 && prev[i] !== 1'b1) begin
          t_up[i] = $time; up_ok[i] = mon_en && rst_n; rises[i]++;
        end else if (aux_out[i] === 1'b0 && prev[i] === 1'b1) begin
          if (up_ok[i] && mon_en && ($time - t_up[i]) < HALF[i]) begin
            runts++;
            $display("runt on aux %0d: %0t ns", i, $time - t_up[i]);
          end
        end
      end
      prev = aux_out;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_running(input string req);
    int snap [N];
    for (int i = 0; i < N; i++) snap[i] = rises[i];
    #400;
    for (int i = 0; i < N; i++)
      chk(rises[i] > snap[i] + 1, req, rises[i] - snap[i], 2);
  endtask

  task automatic check_parked(input string req);
    int bad = 0;
    for (int k = 0; k < 60; k++) begin
      #7;
      if (aux_out !== '0) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic req_level(input logic v);
    @(negedge cpu_clk_c);
    pd_req_n = v;
  endtask

  task automatic t_reset_state;
    // R8: outputs running during reset
    chk(cpu_t_oe === 1'b1 && cpu_c_oe === 1'b1, "R8 oe", {cpu_t_oe, cpu_c_oe}, 3);
    chk(pd_status === 1'b0, "R8 status", pd_status, 0);
  endtask

  task automatic t_single_low;
    // R1: low seen at exactly one rising edge
    req_level(1'b0);
    req_level(1'b1);
    #200;
    chk(cpu_c_oe === 1'b1, "R1 cpu_c_oe", cpu_c_oe, 1);
    chk(pd_status === 1'b0, "R1 status", pd_status, 0);
    check_running("R1 aux running");
  endtask

  task automatic t_enter(input bit tri_mode);
    cpu_tri_en = tri_mode;
    req_level(1'b0);
    #800;
    chk(pd_status === 1'b1, "R9 status set", pd_status, 1);
    check_parked("R2 R5 aux held low");
    if (!tri_mode) begin
      chk(cpu_t_out === 1'b1 && cpu_t_oe === 1'b1, "R3 true leg high",
          {cpu_t_out, cpu_t_oe}, 3);
      chk(cpu_c_oe === 1'b0 && cpu_c_out === 1'b0, "R3 comp released",
          {cpu_c_oe, cpu_c_out}, 0);
    end else begin
      chk(cpu_t_oe === 1'b0 && cpu_c_oe === 1'b0, "R4 both tri",
          {cpu_t_oe, cpu_c_oe}, 0);
    end
  endtask

  task automatic t_blip_high;
    // R7: one high sample during power-down is ignored
    req_level(1'b1);
    req_level(1'b0);
    #200;
    chk(pd_status === 1'b1, "R7 blip status", pd_status, 1);
    chk(cpu_c_oe === 1'b0, "R7 blip cpu_c_oe", cpu_c_oe, 0);
    check_parked("R7 blip aux");
  endtask

  task automatic t_exit;
    req_level(1'b1);
    #800;
    chk(pd_status === 1'b0, "R9 status clear", pd_status, 0);
    chk(cpu_t_oe === 1'b1 && cpu_c_oe === 1'b1, "R7 oe back", {cpu_t_oe, cpu_c_oe}, 3);
    check_running("R7 aux running");
  endtask

  task automatic t_reset_mid;
    req_level(1'b0);
    #800;
    mon_en = 1'b0;
    pd_req_n = 1'b1;
    rst_n = 1'b0;
    #1;
    chk(cpu_t_oe === 1'b1 && cpu_c_oe === 1'b1, "R8 mid oe", {cpu_t_oe, cpu_c_oe}, 3);
    chk(pd_status === 1'b0, "R8 mid status", pd_status, 0);
    #20;
    rst_n = 1'b1;
    #200;
    mon_en = 1'b1;
    check_running("R8 aux after reset");
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pd_req_n = 1'b1; cpu_tri_en = 1'b0;
    #23;
    t_reset_state();
    rst_n = 1'b1;
    #100;
    check_running("R8 running after reset");
    t_single_low();
    t_enter(1'b0);
    t_blip_high();
    t_exit();
    t_enter(1'b1);
    t_exit();
    cpu_tri_en = 1'b0;
    t_reset_mid();
    chk(runts == 0, "R6 no runt pulses", runts, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule